// File: doc/BRIEF.md
# Two-Street Right-of-Way Controller

This block decides which of two streets, A and B, holds the right of way at a crossing. Each street has a car-present input. Each street also has a three-lamp output that shows green, yellow or red. The streets have equal standing. The green stays where it is until a car is waiting on the street that is stopped. Even then, the current street first serves a guaranteed minimum green. It then passes through a fixed-length yellow before the other street turns green.

All timing is counted in clock cycles by an internal dwell counter, so no external timer is needed. The counter clears each time the controller enters a new phase and stops counting at the largest span it has to measure. A synchronous reset puts the crossing in its safe starting phase: A green, B red. The controller accepts requests as soon as the reset is released.

Top module: `street_arbiter`

## Requirements
- R1: Each lamp output is one-hot with green on bit 2 (3'b100), yellow on bit 1 (3'b010) and red on bit 0 (3'b001).
- R2: Whenever one street shows green or yellow, the other street shows red.
- R3: While A is green and `car_b` is low, A stays green on the next cycle, for any number of cycles.
- R4: When A is green, has completed its minimum green and samples `car_b` high, A shows yellow for exactly YEL_CYCLES cycles (default 1). A then turns red and B turns green on the following cycle.
- R5: When B is green, has completed its minimum green and samples `car_a` high, B shows yellow for exactly YEL_CYCLES cycles. B then turns red and A turns green.
- R6: While B is green and `car_a` is low, B stays green.
- R7: After any change of right of way, and after reset, the new green street keeps its green for at least MIN_GREEN cycles (default 2), even if the other street has demand throughout.
- R8: Reset is synchronous and active-high. On the cycle after `rst` is sampled high, the outputs show A green and B red, and they hold there while `rst` stays high. This is reached within one cycle, well inside a six-cycle bound. After release, a waiting car on B is served once A's minimum green is complete.
- R9: A car-present input for the street that already holds green has no effect on the lamps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_a | input | 1 | A car is waiting on street A |
| car_b | input | 1 | A car is waiting on street B |
| lamp_a | output | 3 | Street A lamps, one-hot {green, yellow, red} |
| lamp_b | output | 3 | Street B lamps, one-hot {green, yellow, red} |

## Verification
The hardest case to reach from the ports is demand on the stopped street that arrives on the very first cycle of a fresh green. Only the minimum-green guard keeps that green from being cut short. The stimulus creates this case in two ways. First, it raises `car_a` on the cycle B first turns green and drops `car_b` at the same moment. Second, it holds both car inputs high for a long run, so every green is entered with demand already pending. It also raises `car_b` on the first cycle after a reset is released. A reference model in the bench predicts the lamps for every cycle, so each of these cycles is compared.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    PH_A_GO   = 2'd0,
    PH_A_WARN = 2'd1,
    PH_B_GO   = 2'd2,
    PH_B_WARN = 2'd3
  } phase_t;

  localparam logic [2:0] LAMP_GO   = 3'b100;
  localparam logic [2:0] LAMP_WARN = 3'b010;
  localparam logic [2:0] LAMP_STOP = 3'b001;

  // Lamp pattern that a given street shows in a given phase.
  function automatic logic [2:0] lamp_for(phase_t ph, logic side_b);
    logic owner_b;
    owner_b = ph[1];
    if (owner_b != side_b) return LAMP_STOP;
    return ph[0] ? LAMP_WARN : LAMP_GO;
  endfunction

  // A span of 'span' cycles is complete once 'dwell' full cycles have passed
  // and the current one is the last.
  function automatic logic span_met(int unsigned dwell, int unsigned span);
    return (dwell + 1) >= span;
  endfunction

  // Green phase of the street that does not own the given phase.
  function automatic phase_t rival_go(phase_t ph);
    return ph[1] ? PH_A_GO : PH_B_GO;
  endfunction

endpackage

// File: rtl/arb_dwell.sv
module arb_dwell #(
  parameter int MIN_GREEN  = 2,
  parameter int YEL_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic green_met,
  output logic warn_met
);
  import arb_pkg::*;

  localparam int SPAN_MAX = (MIN_GREEN > YEL_CYCLES) ? MIN_GREEN : YEL_CYCLES;
  localparam int LIMIT    = SPAN_MAX - 1;
  localparam int CNT_W    = $clog2(LIMIT + 2);

  logic [CNT_W-1:0] dwell;
  logic             at_limit;

  assign at_limit = (dwell >= CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || restart) dwell <= '0;
    else if (!at_limit) dwell <= dwell + CNT_W'(1);
  end

  assign green_met = span_met(int'(unsigned'(dwell)), MIN_GREEN);
  assign warn_met  = span_met(int'(unsigned'(dwell)), YEL_CYCLES);

  // R7: the counter never runs past the longest span it must measure
  a_r7_dwell_saturates: assert property (@(posedge clk) disable iff (rst)
    dwell <= CNT_W'(LIMIT));

  // R7: a restart always lands the counter on zero
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> dwell == '0);

endmodule

// File: rtl/arb_phase.sv
module arb_phase (
  input  logic            clk,
  input  logic            rst,
  input  logic            car_a,
  input  logic            car_b,
  input  logic            green_met,
  input  logic            warn_met,
  output arb_pkg::phase_t phase,
  output logic            leave
);
  import arb_pkg::*;

  phase_t nxt;
  logic   give_way;   // a green is ending this cycle
  logic   hand_over;  // a yellow is ending this cycle

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_A_GO:   if (car_b && green_met) nxt = PH_A_WARN;
      PH_A_WARN: if (warn_met)           nxt = rival_go(phase);
      PH_B_GO:   if (car_a && green_met) nxt = PH_B_WARN;
      PH_B_WARN: if (warn_met)           nxt = rival_go(phase);
      default:                           nxt = PH_A_GO;
    endcase
  end

  assign leave     = (nxt != phase);
  assign give_way  = leave && !phase[0];
  assign hand_over = leave &&  phase[0];

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_A_GO;
    else     phase <= nxt;
  end

  // R4, R5: a yellow always ends in the other street's green
  a_r5_hand_over_flips: assert property (@(posedge clk) disable iff (rst)
    hand_over |=> (!phase[0] && (phase[1] != $past(phase[1]))));

  // R4, R5: a green only ever ends by moving to its own street's yellow
  a_r4_give_way_warns: assert property (@(posedge clk) disable iff (rst)
    give_way |=> (phase[0] && (phase[1] == $past(phase[1]))));

endmodule

// File: rtl/arb_lamps.sv
module arb_lamps (
  input  logic            clk,
  input  logic            rst,
  input  arb_pkg::phase_t phase,
  output logic [2:0]      lamp_a,
  output logic [2:0]      lamp_b
);
  import arb_pkg::*;

  assign lamp_a = lamp_for(phase, 1'b0);
  assign lamp_b = lamp_for(phase, 1'b1);

  // R1: exactly one lamp lit per street
  a_r1_onehot_a: assert property (@(posedge clk) disable iff (rst)
    $countones(lamp_a) == 1);
  a_r1_onehot_b: assert property (@(posedge clk) disable iff (rst)
    $countones(lamp_b) == 1);

endmodule

// File: rtl/street_arbiter.sv
module street_arbiter #(
  parameter int MIN_GREEN  = 2,
  parameter int YEL_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_a,
  input  logic       car_b,
  output logic [2:0] lamp_a,
  output logic [2:0] lamp_b
);
  import arb_pkg::*;

  phase_t phase;
  logic   leave;
  logic   green_met;
  logic   warn_met;

  arb_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .car_a     (car_a),
    .car_b     (car_b),
    .green_met (green_met),
    .warn_met  (warn_met),
    .phase     (phase),
    .leave     (leave)
  );

  arb_dwell #(
    .MIN_GREEN  (MIN_GREEN),
    .YEL_CYCLES (YEL_CYCLES)
  ) u_dwell (
    .clk       (clk),
    .rst       (rst),
    .restart   (leave),
    .green_met (green_met),
    .warn_met  (warn_met)
  );

  arb_lamps u_lamps (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .lamp_a (lamp_a),
    .lamp_b (lamp_b)
  );

  // R2: no two streets off red at once
  a_r2_cross_exclusive: assert property (@(posedge clk) disable iff (rst)
    (lamp_a != LAMP_STOP) |-> (lamp_b == LAMP_STOP));

  // R3: A keeps green without demand on B
  a_r3_a_holds: assert property (@(posedge clk) disable iff (rst)
    (lamp_a == LAMP_GO && !car_b) |=> lamp_a == LAMP_GO);

  // R6: B keeps green without demand on A
  a_r6_b_holds: assert property (@(posedge clk) disable iff (rst)
    (lamp_b == LAMP_GO && !car_a) |=> lamp_b == LAMP_GO);

  // R4: A only turns yellow after B asked
  a_r4_warn_after_demand: assert property (@(posedge clk) disable iff (rst)
    $rose(lamp_a == LAMP_WARN) |-> $past(car_b));

  // R5: B only turns yellow after A asked
  a_r5_warn_after_demand: assert property (@(posedge clk) disable iff (rst)
    $rose(lamp_b == LAMP_WARN) |-> $past(car_a));

  // R8: reset lands on A green, B red one cycle later
  a_r8_reset_lands: assert property (@(posedge clk)
    rst |=> (lamp_a == LAMP_GO && lamp_b == LAMP_STOP));

  generate
    if (YEL_CYCLES == 1) begin : g_short_warn
      // R4: a one-cycle yellow on A is followed by B green
      a_r4_warn_len: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == LAMP_WARN) |=> (lamp_a == LAMP_STOP && lamp_b == LAMP_GO));
    end
    if (MIN_GREEN >= 2) begin : g_min_green
      // R7: a fresh B green survives its second cycle
      a_r7_b_min_green: assert property (@(posedge clk) disable iff (rst)
        $rose(lamp_b == LAMP_GO) |=> lamp_b == LAMP_GO);
      // R7: a fresh A green survives its second cycle
      a_r7_a_min_green: assert property (@(posedge clk) disable iff (rst)
        $rose(lamp_a == LAMP_GO) |=> lamp_a == LAMP_GO);
    end
  endgenerate

endmodule

// File: tb/sim_street_arbiter.sv
`timescale 1ns/100ps
module sim_street_arbiter;

  localparam int MING = 2;
  localparam int YEL  = 1;
  localparam logic [2:0] GO = 3'b100, WARN = 3'b010, STOP = 3'b001;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car_a = 1'b0;
  logic       car_b = 1'b0;
  logic [2:0] lamp_a, lamp_b;

  street_arbiter #(.MIN_GREEN(MING), .YEL_CYCLES(YEL)) u0 (
    .clk(clk), .rst(rst), .car_a(car_a), .car_b(car_b),
    .lamp_a(lamp_a), .lamp_b(lamp_b)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;

  int         q_due[$];
  logic [5:0] q_exp[$];
  string      q_tag[$];

  // reference model: owner (0=A,1=B), in yellow, cycles done in phase
  bit m_own = 0;
  bit m_yel = 0;
  int m_cnt = 0;

  function automatic logic [2:0] m_lamp(bit side);
    if (m_own != side) return STOP;
    return m_yel ? WARN : GO;
  endfunction

  // drive one cycle of inputs and queue the lamps expected after the next edge
  task automatic step(bit r, bit ca, bit cb, string tag);
    bit dem;
    rst = r; car_a = ca; car_b = cb;
    if (r) begin
      m_own = 0; m_yel = 0; m_cnt = 0;
    end else if (!m_yel) begin
      dem = m_own ? ca : cb;
      if (dem && (m_cnt + 1 >= MING)) begin m_yel = 1; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end else begin
      if (m_cnt + 1 >= YEL) begin m_yel = 0; m_own = !m_own; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
    q_due.push_back(cyc + 1);
    q_exp.push_back({m_lamp(0), m_lamp(1)});
    q_tag.push_back(tag);
    @(posedge clk); #1;
  endtask

  // monitor: compare every due item half a cycle after its edge
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      logic [5:0] e;
      string      t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      n_checks++;
      if ({lamp_a, lamp_b} !== e) begin
        n_fail++;
        $display("FAIL %s cycle %0d: lamps a=%b b=%b, expected a=%b b=%b",
                 t, cyc, lamp_a, lamp_b, e[5:3], e[2:0]);
      end
      // R1, R2: shape of every lamp pair
      n_checks++;
      if ($countones(lamp_a) != 1 || $countones(lamp_b) != 1 ||
          (lamp_a != STOP && lamp_b != STOP)) begin
        n_fail++;
        $display("FAIL R1/R2 cycle %0d: lamps a=%b b=%b, expected one-hot with one red",
                 cyc, lamp_a, lamp_b);
      end
    end
  end

  initial begin
    // R8: reset held for several cycles
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R8 reset held");
    // R3: no demand, A stays green
    for (int i = 0; i < 6; i++) step(0, 0, 0, "R3 A idle");
    // R9: demand on A while A already green changes nothing
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R9 own-street car");
    // R4: demand on B, A yellow one cycle then B green
    step(0, 0, 1, "R4 A to yellow");
    step(0, 0, 1, "R4 B green");
    // R6: B keeps green while A is empty
    for (int i = 0; i < 5; i++) step(0, 0, 1, "R6 B idle");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R6 B no demand");
    // R5: A asks, B yields through yellow
    step(0, 1, 0, "R5 B to yellow");
    step(0, 1, 0, "R5 A green");
    // R7: B asks on A's first green cycle; A holds its minimum first
    step(0, 0, 1, "R7 A min green 1");
    step(0, 0, 1, "R7 A min green 2");
    step(0, 1, 0, "R7 B green after yellow");
    // R7: A asks on B's first green cycle, B asks no more
    step(0, 1, 0, "R7 B min green");
    step(0, 1, 0, "R7 B min green end");
    step(0, 1, 0, "R5 back to A");
    // R7, R2: both streets demand continuously, phases alternate
    for (int i = 0; i < 16; i++) step(0, 1, 1, "R7 both waiting");
    // R8: reset in the middle of service
    step(0, 1, 1, "R7 both waiting");
    step(1, 1, 1, "R8 reset mid-run");
    step(1, 0, 1, "R8 reset held");
    // R8: B served after A's minimum green once released
    for (int i = 0; i < 6; i++) step(0, 0, 1, "R8 after release");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R6 settle");
    @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule